// File: doc/BRIEF.md
# Alpha-Multiplier Word LFSR

This block holds sixteen 32-bit words in a shift register whose feedback is built from finite-field arithmetic over GF(2^8). It is the linear half of a word-oriented stream cipher. A surrounding controller loads the starting state and steps the register once per keystream word. During the warm-up phase, it also feeds back a 32-bit word from an external nonlinear stage.

The feedback word combines five terms:

- the lowest stage shifted up one byte;
- the alpha-multiply image of that stage's top byte;
- stage 2;
- stage 11 shifted down one byte;
- the alpha-divide image of stage 11's bottom byte.

Both alpha maps are linear in their byte input. Each is therefore built as an XOR of eight 32-bit constant columns, and those columns are evaluated when the design is elaborated.

A mode input picks whether the external word is XORed into the feedback. A load strobe replaces the whole state in one cycle.

Top module: `alpha_word_lfsr`

## Requirements
- R1: A synchronous, active-high `rst` clears all sixteen stages to zero on the next rising edge. It takes priority over load and step.
- R2: Load writes the whole state in one cycle. While `load_en` is high, the next edge copies `load_bus` into the state, and stage k takes bits [32k+31:32k]. `stage_bus` presents stage k on the same bit positions.
- R3: When `load_en` and `step_en` are both high, the load wins and no shift occurs.
- R4: With neither strobe high, every stage keeps its value whatever `init_mode` and `f_word` do.
- R5: On a step, stage k takes the old stage k+1 for k from 0 to 14, and stage 15 takes the feedback word.
- R6: Doubling a byte shifts it left by one and XORs in 0xA9 if the old bit 7 was set. Alpha-multiply of byte c is a word whose bytes, from most to least significant, are c doubled 23, 245, 48 and 239 times.
- R7: Alpha-divide of byte c is a word whose bytes, from most to least significant, are c doubled 16, 39, 6 and 64 times, with the same doubling as in R6.
- R8: The keystream feedback (`init_mode` low) is the XOR of five words:
  - {S0[23:0], 8'h00};
  - alpha-multiply(S0[31:24]);
  - S2;
  - {8'h00, S11[31:8]};
  - alpha-divide(S11[7:0]).
- R9: With `init_mode` high, the feedback word is additionally XORed with `f_word`.
- R10: With `init_mode` low, the value of `f_word` has no effect on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Load the whole state from `load_bus` |
| load_bus | input | 512 | New state, stage k at bits [32k+31:32k] |
| step_en | input | 1 | Advance the register by one word |
| init_mode | input | 1 | 1: inject `f_word` into the feedback |
| f_word | input | 32 | External word for initialization mode |
| stage_bus | output | 512 | Current state, stage k at bits [32k+31:32k] |

## Verification
The hard cases are the high-exponent columns of the alpha maps, such as the 245-fold and 239-fold doublings. Any single wrong column is hidden under the XOR of the other feedback terms when the state is random. To expose them, the stimulus loads states in which only stage 0's top byte, or only stage 11's bottom byte, is non-zero. Each step then isolates one map. These isolating loads sweep single-bit bytes and the all-ones byte. Long random runs in both modes, with `f_word` changing every cycle, compare the whole state each clock against a queue-based model.

// File: rtl/alpha_lfsr_pkg.sv
package alpha_lfsr_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned BYTE_W     = 8;
    localparam logic [7:0]  FIELD_POLY = 8'hA9;

    // one conditional-XOR doubling step in GF(2^8)
    function automatic logic [7:0] gf_double(input logic [7:0] v, input logic [7:0] poly);
        logic [7:0] sh;
        sh = {v[6:0], 1'b0};
        return v[7] ? (sh ^ poly) : sh;
    endfunction

    // n doublings, evaluated only on constants at elaboration
    function automatic logic [7:0] gf_double_n(input logic [7:0] v, input int unsigned n,
                                               input logic [7:0] poly);
        logic [7:0] r;
        r = v;
        for (int unsigned i = 0; i < n; i++) r = gf_double(r, poly);
        return r;
    endfunction

    // word image of a byte: four doubling counts, most significant byte first
    function automatic logic [31:0] spread_word(input logic [7:0] c,
                                                input int unsigned e3, input int unsigned e2,
                                                input int unsigned e1, input int unsigned e0);
        return {gf_double_n(c, e3, FIELD_POLY), gf_double_n(c, e2, FIELD_POLY),
                gf_double_n(c, e1, FIELD_POLY), gf_double_n(c, e0, FIELD_POLY)};
    endfunction

endpackage

// File: rtl/alpha_map.sv
module alpha_map
    import alpha_lfsr_pkg::*;
#(
    parameter int unsigned EXP3 = 23,
    parameter int unsigned EXP2 = 245,
    parameter int unsigned EXP1 = 48,
    parameter int unsigned EXP0 = 239
) (
    input  logic [BYTE_W-1:0] byte_i,
    output logic [WORD_W-1:0] word_o
);

    logic [WORD_W-1:0] col_sel [BYTE_W];

    // the map is linear: one constant column per input bit
    for (genvar b = 0; b < BYTE_W; b++) begin : g_col
        localparam logic [7:0]        UNIT = 8'(1 << b);
        localparam logic [WORD_W-1:0] COL  = spread_word(UNIT, EXP3, EXP2, EXP1, EXP0);
        assign col_sel[b] = byte_i[b] ? COL : '0;
    end

    always_comb begin
        word_o = '0;
        for (int b = 0; b < BYTE_W; b++) word_o ^= col_sel[b];
    end

endmodule

// File: rtl/lfsr_feedback.sv
module lfsr_feedback
    import alpha_lfsr_pkg::*;
(
    input  logic [WORD_W-1:0] s_low,
    input  logic [WORD_W-1:0] s_mid,
    input  logic [WORD_W-1:0] s_high,
    input  logic [WORD_W-1:0] f_word,
    input  logic              inject,
    output logic [WORD_W-1:0] fb_o
);

    logic [WORD_W-1:0] mul_w;
    logic [WORD_W-1:0] div_w;

    alpha_map #(.EXP3(23), .EXP2(245), .EXP1(48), .EXP0(239)) u_mul (
        .byte_i (s_low[WORD_W-1 -: BYTE_W]),
        .word_o (mul_w)
    );

    alpha_map #(.EXP3(16), .EXP2(39), .EXP1(6), .EXP0(64)) u_div (
        .byte_i (s_high[BYTE_W-1:0]),
        .word_o (div_w)
    );

    always_comb begin
        fb_o = {s_low[WORD_W-BYTE_W-1:0], {BYTE_W{1'b0}}}
             ^ mul_w
             ^ s_mid
             ^ {{BYTE_W{1'b0}}, s_high[WORD_W-1:BYTE_W]}
             ^ div_w;
        if (inject) fb_o ^= f_word;
    end

endmodule

// File: rtl/alpha_word_lfsr.sv
module alpha_word_lfsr
    import alpha_lfsr_pkg::*;
#(
    parameter int unsigned NSTAGE  = 16,
    parameter int unsigned TAP_MID = 2,
    parameter int unsigned TAP_HI  = 11,
    localparam int unsigned BUS_W  = NSTAGE * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [BUS_W-1:0]  load_bus,
    input  logic              step_en,
    input  logic              init_mode,
    input  logic [WORD_W-1:0] f_word,
    output logic [BUS_W-1:0]  stage_bus
);

    typedef struct packed {
        logic [NSTAGE-1:0][WORD_W-1:0] stg;
    } state_t;

    state_t            st_d, st_q;
    logic [WORD_W-1:0] fb_word;

    lfsr_feedback u_fb (
        .s_low  (st_q.stg[0]),
        .s_mid  (st_q.stg[TAP_MID]),
        .s_high (st_q.stg[TAP_HI]),
        .f_word (f_word),
        .inject (init_mode),
        .fb_o   (fb_word)
    );

    always_comb begin
        st_d = st_q;
        if (load_en) begin
            st_d.stg = load_bus;
        end else if (step_en) begin
            for (int k = 0; k < NSTAGE - 1; k++) st_d.stg[k] = st_q.stg[k+1];
            st_d.stg[NSTAGE-1] = fb_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign stage_bus = st_q.stg;

endmodule

// File: rtl/alpha_lfsr_chk.sv
module alpha_lfsr_chk #(
    parameter int unsigned BUS_W = 512,
    parameter int unsigned W     = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             load_en,
    input logic             step_en,
    input logic [BUS_W-1:0] load_bus,
    input logic [BUS_W-1:0] stage_bus
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> stage_bus == '0);

    a_r2_load_copies: assert property (@(posedge clk) disable iff (rst)
        load_en |=> stage_bus == $past(load_bus));

    a_r4_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !step_en) |=> $stable(stage_bus));

    a_r5_shift_down: assert property (@(posedge clk) disable iff (rst)
        (step_en && !load_en) |=> stage_bus[BUS_W-W-1:0] == $past(stage_bus[BUS_W-1:W]));

endmodule

bind alpha_word_lfsr alpha_lfsr_chk #(.BUS_W(BUS_W), .W(alpha_lfsr_pkg::WORD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .load_en   (load_en),
    .step_en   (step_en),
    .load_bus  (load_bus),
    .stage_bus (stage_bus)
);

// File: tb/test_alpha_word_lfsr.sv
module test_alpha_word_lfsr;

    localparam int N = 16;
    localparam int BW = N * 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_en = 1'b0;
    logic [BW-1:0] load_bus = '0;
    logic          step_en = 1'b0;
    logic          init_mode = 1'b0;
    logic [31:0]   f_word = '0;
    logic [BW-1:0] stage_bus;

    int errs = 0;
    int checks = 0;
    bit done = 0;

    logic [31:0] ref_q [$];

    always #2.5 clk = ~clk;

    alpha_word_lfsr i_alpha_word_lfsr (
        .clk(clk), .rst(rst), .load_en(load_en), .load_bus(load_bus),
        .step_en(step_en), .init_mode(init_mode), .f_word(f_word), .stage_bus(stage_bus)
    );

    function automatic logic [7:0] dbl(input logic [7:0] v, input int n);
        logic [7:0] r = v;
        for (int i = 0; i < n; i++) r = r[7] ? ((r << 1) ^ 8'hA9) : (r << 1);
        return r;
    endfunction

    function automatic logic [31:0] amul(input logic [7:0] c);
        return {dbl(c, 23), dbl(c, 245), dbl(c, 48), dbl(c, 239)};
    endfunction

    function automatic logic [31:0] adiv(input logic [7:0] c);
        return {dbl(c, 16), dbl(c, 39), dbl(c, 6), dbl(c, 64)};
    endfunction

    // advance the model on the edge, then compare away from it
    task automatic tick(input string req);
        logic [31:0] fb;
        @(posedge clk);
        if (rst) begin
            ref_q = {};
            for (int k = 0; k < N; k++) ref_q.push_back(32'h0);
        end else if (load_en) begin
            ref_q = {};
            for (int k = 0; k < N; k++) ref_q.push_back(load_bus[32*k +: 32]);
        end else if (step_en) begin
            fb = (ref_q[0] << 8) ^ amul(ref_q[0][31:24]) ^ ref_q[2]
               ^ (ref_q[11] >> 8) ^ adiv(ref_q[11][7:0]);
            if (init_mode) fb ^= f_word;
            void'(ref_q.pop_front());
            ref_q.push_back(fb);
        end
        @(negedge clk);
        checks++;
        for (int k = 0; k < N; k++) begin
            if (stage_bus[32*k +: 32] !== ref_q[k]) begin
                errs++;
                $display("FAIL %s stage %0d: actual %08h expected %08h",
                         req, k, stage_bus[32*k +: 32], ref_q[k]);
                break;
            end
        end
    endtask

    task automatic load_one(input int idx, input logic [31:0] val, input string req);
        load_bus = '0;
        load_bus[32*idx +: 32] = val;
        load_en = 1; step_en = 0;
        tick("R2");
        load_en = 0; step_en = 1; init_mode = 0; f_word = $urandom;
        tick(req);
        step_en = 0;
    endtask

    initial begin
        for (int k = 0; k < N; k++) ref_q.push_back(32'h0);
        // R1: reset, even with load and step asserted
        load_en = 1; step_en = 1;
        for (int k = 0; k < N; k++) load_bus[32*k +: 32] = $urandom;
        tick("R1");
        tick("R1");
        rst = 0; load_en = 0; step_en = 0;
        // R4: idle holds zero
        init_mode = 1; f_word = 32'hDEADBEEF;
        tick("R4");
        // R2: full load
        for (int k = 0; k < N; k++) load_bus[32*k +: 32] = $urandom;
        load_en = 1;
        tick("R2");
        load_en = 0;
        // R4: hold under changing mode and F
        for (int i = 0; i < 3; i++) begin
            init_mode = i[0]; f_word = $urandom;
            tick("R4");
        end
        // R3: load beats step
        for (int k = 0; k < N; k++) load_bus[32*k +: 32] = $urandom;
        load_en = 1; step_en = 1;
        tick("R3");
        load_en = 0;
        // R5, R8, R10: keystream steps with F toggling
        init_mode = 0;
        for (int i = 0; i < 40; i++) begin
            f_word = $urandom;
            tick("R10");
        end
        step_en = 0;
        // R6: isolate alpha-multiply columns
        for (int b = 0; b < 8; b++) load_one(0, {8'(1 << b), 24'h0}, "R6");
        load_one(0, 32'hFF00_0000, "R6");
        // R7: isolate alpha-divide columns
        for (int b = 0; b < 8; b++) load_one(11, {24'h0, 8'(1 << b)}, "R7");
        load_one(11, 32'h0000_00FF, "R7");
        // R8: shifted-word and middle-tap terms
        load_one(0, 32'h00A5_5A3C, "R8");
        load_one(11, 32'h1234_5600, "R8");
        load_one(2, 32'hCAFE_F00D, "R8");
        // R9: initialization mode injects F
        for (int k = 0; k < N; k++) load_bus[32*k +: 32] = $urandom;
        load_en = 1;
        tick("R2");
        load_en = 0; step_en = 1; init_mode = 1;
        for (int i = 0; i < 32; i++) begin
            f_word = $urandom;
            tick("R9");
        end
        // R9: zero state with F makes F appear in stage 15
        step_en = 0; load_bus = '0; load_en = 1;
        tick("R2");
        load_en = 0; step_en = 1; f_word = 32'h0BAD_F00D;
        tick("R9");
        // R5: mixed-mode run then R1 mid-run reset
        for (int i = 0; i < 20; i++) begin
            init_mode = i[1]; f_word = $urandom;
            tick("R5");
        end
        rst = 1;
        tick("R1");
        rst = 0; step_en = 0;
        tick("R4");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule